// File: doc/BRIEF.md
# Interrupt Controller Command Front End

This block is the programming front end of an eight-level interrupt controller. A processor writes command bytes and reads status through one 8-bit port pair, selected by a single address bit (even or odd). The block tells command bytes apart, walks a four-byte setup sequence, and keeps the vector base, the cascade identity and the special nested-mode flag. After setup it turns runtime bytes into actions: mask loads, priority and end-of-interrupt commands, changes of mask mode, selection of the register that reads return, and poll requests.

The priority resolver is a separate block. This block reaches it only through ports. It receives the request vector, the in-service vector and the highest pending level. It sends out the mask, a one-cycle command strobe with a code and a level, a priority-restore strobe when setup begins, and an acknowledge strobe when a read consumes a poll.

Top module: `pic_cmd_frontend`

## Requirements
- R1: After reset, `init_done`, `special_mask`, `nested_special`, `cmd_valid`, `prio_restore` and `poll_ack` are 0, `mask_vec` is 0, `vec_base` is 0, `cascade_id` is 7, and `rdata` is 0 while no read is active.
- R2: An even-port write with data bit 4 set starts setup. This can happen at any time, including during an earlier setup. On the clock that takes the write, `init_done` goes to 0, the mask clears, special mask mode clears, `nested_special` clears, `cascade_id` becomes 7 and even-port reads select the request vector. `prio_restore` is high for exactly the next cycle.
- R3: The next three odd-port writes complete setup. The first loads `vec_base` from data bits 7-3. The second loads `cascade_id` with the full byte. The third loads `nested_special` from data bit 4 and raises `init_done`.
- R4: Odd-port writes never change the mask while `init_done` is 0. This covers writes before any setup and writes that are part of the setup sequence.
- R5: While `init_done` is 1, an odd-port write loads all eight mask bits, and an odd-port read returns the mask.
- R6: An even-port write with bits 4 and 3 clear, while `init_done` is 1, is a priority command. `cmd_valid` is high for the following cycle, with `cmd_code` equal to data bits 7-5 and `cmd_level` equal to bits 2-0. Codes 000, 010 and 100 do nothing and raise no strobe.
- R7: An even-port write with bit 4 clear and bit 3 set is the mode byte. While `init_done` is 1, bits 6-5 of 10 clear `special_mask`, 11 set it, and any other value leaves it unchanged.
- R8: In the mode byte, bits 1-0 of 10 make even-port reads return `req_vec`, and 11 make them return `isr_vec`. Other values leave the choice unchanged. The choice persists across any number of reads.
- R9: Mode-byte bit 2 arms a poll. The next read, from either port, returns {`pend_valid`, 0000, level} and raises `poll_ack` for that read cycle. The level is `pend_level` when `pend_valid` is 1 and 0 otherwise. The poll is consumed by that read, so the read after it returns normal data.
- R10: While `init_done` is 0, priority and mode bytes have no effect: no strobe, no change of mask mode, read selection or poll state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, one cycle per byte |
| rd_en | input | 1 | Read strobe, one cycle per read |
| addr_odd | input | 1 | 1 selects the odd port, 0 the even port |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid while rd_en is high, 0 otherwise |
| req_vec | input | 8 | Request vector from the priority logic |
| isr_vec | input | 8 | In-service vector from the priority logic |
| pend_valid | input | 1 | An unmasked request is pending |
| pend_level | input | 3 | Highest pending level |
| mask_vec | output | 8 | Current mask |
| vec_base | output | 5 | Upper five bits of the interrupt vector |
| cascade_id | output | 8 | Cascade identity byte |
| nested_special | output | 1 | Special fully-nested mode selected |
| init_done | output | 1 | Setup sequence complete |
| special_mask | output | 1 | Special mask mode active |
| prio_restore | output | 1 | One-cycle strobe: restore default priority order |
| cmd_valid | output | 1 | One-cycle priority/end-of-interrupt command strobe |
| cmd_code | output | 3 | Command code, valid with cmd_valid |
| cmd_level | output | 3 | Command level, valid with cmd_valid |
| poll_ack | output | 1 | This read consumes a poll and acts as an acknowledge |

## Verification
The bench restarts setup in the middle of a sequence and confirms that the next odd byte is taken as the vector base again. A design that did not restart would store that byte as the cascade identity or the options byte instead. It writes odd bytes before and during setup and reads the mask back, which catches a design that loads the mask too early and corrupts it during setup. It sends the no-action codes of both runtime bytes and checks that neither the strobe nor the modes move. It also reads the in-service vector twice after one select, reads twice after a poll, and polls with nothing pending. These catch a non-sticky selection, a poll that never clears, and a status byte that leaks a stale level.

// File: rtl/pic_fe_pkg.sv
package pic_fe_pkg;

    localparam int DATA_W   = 8;
    localparam int LEVEL_W  = 3;
    localparam int BASE_W   = 5;
    localparam int CODE_W   = 3;

    // bit positions that the command decode depends on
    localparam int START_BIT = 4;
    localparam int MODE_BIT  = 3;
    localparam int POLL_BIT  = 2;
    localparam int SFN_BIT   = 4;
    localparam int BASE_LSB  = DATA_W - BASE_W;

    localparam logic [DATA_W-1:0] CASC_DEFAULT = DATA_W'(7);

    typedef enum logic [2:0] {
        WK_NONE,
        WK_START,
        WK_ODD,
        WK_PRIO,
        WK_MODE
    } wkind_e;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_BASE,
        ST_CASC,
        ST_OPT,
        ST_RUN
    } seq_e;

    typedef struct packed {
        logic [CODE_W-1:0]  code;
        logic [LEVEL_W-1:0] level;
    } prio_cmd_t;

    function automatic wkind_e classify(input logic wr, input logic odd,
                                        input logic [DATA_W-1:0] d);
        if (!wr)               return WK_NONE;
        if (odd)               return WK_ODD;
        if (d[START_BIT])      return WK_START;
        if (d[MODE_BIT])       return WK_MODE;
        return WK_PRIO;
    endfunction

    // codes that carry an action for the priority logic
    function automatic logic code_acts(input logic [CODE_W-1:0] c);
        return !(c == 3'b000 || c == 3'b010 || c == 3'b100);
    endfunction

endpackage

// File: rtl/pic_init_seq.sv
module pic_init_seq
    import pic_fe_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  wkind_e            kind,
    input  logic [DATA_W-1:0] wdata,
    output logic              start,
    output logic              running,
    output logic              prio_restore,
    output logic [BASE_W-1:0] vec_base,
    output logic [DATA_W-1:0] cascade_id,
    output logic              nested_special
);

    seq_e state_q;

    assign start   = (kind == WK_START);
    assign running = (state_q == ST_RUN);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q        <= ST_OFF;
            prio_restore   <= 1'b0;
            vec_base       <= '0;
            cascade_id     <= CASC_DEFAULT;
            nested_special <= 1'b0;
        end else begin
            prio_restore <= start;
            if (start) begin
                state_q        <= ST_BASE;
                cascade_id     <= CASC_DEFAULT;
                nested_special <= 1'b0;
            end else if (kind == WK_ODD) begin
                unique case (state_q)
                    ST_BASE: begin
                        vec_base <= wdata[DATA_W-1:BASE_LSB];
                        state_q  <= ST_CASC;
                    end
                    ST_CASC: begin
                        cascade_id <= wdata;
                        state_q    <= ST_OPT;
                    end
                    ST_OPT: begin
                        nested_special <= wdata[SFN_BIT];
                        state_q        <= ST_RUN;
                    end
                    default: state_q <= state_q;
                endcase
            end
        end
    end

    assert_seq_done_R3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_OPT && kind == WK_ODD) |=> running);

    assert_start_drops_R2: assert property (@(posedge clk) disable iff (rst)
        start |=> (!running && prio_restore && cascade_id == CASC_DEFAULT));

endmodule

// File: rtl/pic_ocw_decode.sv
module pic_ocw_decode
    import pic_fe_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  wkind_e             kind,
    input  logic [DATA_W-1:0]  wdata,
    input  logic               start,
    input  logic               running,
    input  logic               rd_en,
    output logic [DATA_W-1:0]  mask_q,
    output logic               smm_q,
    output logic               sel_isr_q,
    output logic               poll_q,
    output logic               cmd_valid,
    output prio_cmd_t          cmd_q
);

    logic [1:0]  smm_field;
    logic [1:0]  sel_field;
    prio_cmd_t   cmd_in;
    logic        cmd_fire;

    assign smm_field    = wdata[6:5];
    assign sel_field    = wdata[1:0];
    assign cmd_in.code  = wdata[DATA_W-1:DATA_W-CODE_W];
    assign cmd_in.level = wdata[LEVEL_W-1:0];
    assign cmd_fire     = running && kind == WK_PRIO && code_acts(cmd_in.code);

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q    <= '0;
            smm_q     <= 1'b0;
            sel_isr_q <= 1'b0;
            poll_q    <= 1'b0;
            cmd_valid <= 1'b0;
            cmd_q     <= '0;
        end else begin
            cmd_valid <= cmd_fire;
            if (cmd_fire) cmd_q <= cmd_in;
            if (rd_en) poll_q <= 1'b0;
            if (start) begin
                mask_q    <= '0;
                smm_q     <= 1'b0;
                sel_isr_q <= 1'b0;
                poll_q    <= 1'b0;
            end else if (running) begin
                if (kind == WK_ODD) mask_q <= wdata;
                if (kind == WK_MODE) begin
                    if (smm_field[1])   smm_q     <= smm_field[0];
                    if (sel_field[1])   sel_isr_q <= sel_field[0];
                    if (wdata[POLL_BIT]) poll_q   <= 1'b1;
                end
            end
        end
    end

    assert_mask_frozen_R4: assert property (@(posedge clk) disable iff (rst)
        (!running && !start) |=> $stable(mask_q));

    assert_start_clears_R2: assert property (@(posedge clk) disable iff (rst)
        start |=> (mask_q == '0 && !smm_q && !sel_isr_q && !poll_q));

    assert_cmd_source_R6: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> $past(kind == WK_PRIO && running));

    assert_poll_consumed_R9: assert property (@(posedge clk) disable iff (rst)
        (rd_en && poll_q && !(running && kind == WK_MODE)) |=> !poll_q);

    assert_idle_no_cmd_R10: assert property (@(posedge clk) disable iff (rst)
        !running |=> !cmd_valid);

endmodule

// File: rtl/pic_rd_mux.sv
module pic_rd_mux
    import pic_fe_pkg::*;
(
    input  logic               rd_en,
    input  logic               addr_odd,
    input  logic               poll_armed,
    input  logic               sel_isr,
    input  logic [DATA_W-1:0]  mask_vec,
    input  logic [DATA_W-1:0]  req_vec,
    input  logic [DATA_W-1:0]  isr_vec,
    input  logic               pend_valid,
    input  logic [LEVEL_W-1:0] pend_level,
    output logic [DATA_W-1:0]  rdata,
    output logic               poll_ack
);

    logic [DATA_W-1:0] status;

    always_comb begin
        status = '0;
        status[DATA_W-1] = pend_valid;
        if (pend_valid) status[LEVEL_W-1:0] = pend_level;
    end

    assign poll_ack = rd_en && poll_armed;

    always_comb begin
        if (!rd_en)          rdata = '0;
        else if (poll_armed) rdata = status;
        else if (addr_odd)   rdata = mask_vec;
        else if (sel_isr)    rdata = isr_vec;
        else                 rdata = req_vec;
    end

    always_comb begin
        if (poll_ack && rdata[DATA_W-2:LEVEL_W] != '0)
            assert_status_pad_R9: assert (1'b0);
    end

endmodule

// File: rtl/pic_cmd_frontend.sv
module pic_cmd_frontend
    import pic_fe_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic                addr_odd,
    input  logic [7:0]          wdata,
    output logic [7:0]          rdata,
    input  logic [7:0]          req_vec,
    input  logic [7:0]          isr_vec,
    input  logic                pend_valid,
    input  logic [2:0]          pend_level,
    output logic [7:0]          mask_vec,
    output logic [4:0]          vec_base,
    output logic [7:0]          cascade_id,
    output logic                nested_special,
    output logic                init_done,
    output logic                special_mask,
    output logic                prio_restore,
    output logic                cmd_valid,
    output logic [2:0]          cmd_code,
    output logic [2:0]          cmd_level,
    output logic                poll_ack
);

    wkind_e    kind;
    logic      start;
    logic      sel_isr;
    logic      poll_armed;
    prio_cmd_t cmd;

    assign kind      = classify(wr_en, addr_odd, wdata);
    assign cmd_code  = cmd.code;
    assign cmd_level = cmd.level;

    pic_init_seq u_seq (
        .clk            (clk),
        .rst            (rst),
        .kind           (kind),
        .wdata          (wdata),
        .start          (start),
        .running        (init_done),
        .prio_restore   (prio_restore),
        .vec_base       (vec_base),
        .cascade_id     (cascade_id),
        .nested_special (nested_special)
    );

    pic_ocw_decode u_ocw (
        .clk       (clk),
        .rst       (rst),
        .kind      (kind),
        .wdata     (wdata),
        .start     (start),
        .running   (init_done),
        .rd_en     (rd_en),
        .mask_q    (mask_vec),
        .smm_q     (special_mask),
        .sel_isr_q (sel_isr),
        .poll_q    (poll_armed),
        .cmd_valid (cmd_valid),
        .cmd_q     (cmd)
    );

    pic_rd_mux u_rd (
        .rd_en      (rd_en),
        .addr_odd   (addr_odd),
        .poll_armed (poll_armed),
        .sel_isr    (sel_isr),
        .mask_vec   (mask_vec),
        .req_vec    (req_vec),
        .isr_vec    (isr_vec),
        .pend_valid (pend_valid),
        .pend_level (pend_level),
        .rdata      (rdata),
        .poll_ack   (poll_ack)
    );

    assert_odd_mask_R5: assert property (@(posedge clk) disable iff (rst)
        (init_done && wr_en && addr_odd) |=> (mask_vec == $past(wdata)));

endmodule

// File: tb/tb_pic_cmd_frontend.sv
module tb_pic_cmd_frontend;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0, rd_en = 1'b0, addr_odd = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [7:0] req_vec = 8'h00, isr_vec = 8'h00;
    logic       pend_valid = 1'b0;
    logic [2:0] pend_level = 3'd0;
    logic [7:0] mask_vec, cascade_id;
    logic [4:0] vec_base;
    logic       nested_special, init_done, special_mask, prio_restore;
    logic       cmd_valid, poll_ack;
    logic [2:0] cmd_code, cmd_level;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;

    pic_cmd_frontend dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr_odd(addr_odd),
        .wdata(wdata), .rdata(rdata), .req_vec(req_vec), .isr_vec(isr_vec),
        .pend_valid(pend_valid), .pend_level(pend_level), .mask_vec(mask_vec),
        .vec_base(vec_base), .cascade_id(cascade_id), .nested_special(nested_special),
        .init_done(init_done), .special_mask(special_mask), .prio_restore(prio_restore),
        .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_level(cmd_level),
        .poll_ack(poll_ack)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // drive at a falling edge, release at the next; registered results are visible after
    task automatic wr(input logic odd, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr_odd = odd; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; addr_odd = 1'b0; wdata = '0;
        #1;
    endtask

    task automatic rd(input logic odd, output logic [7:0] d, output logic ack);
        @(negedge clk);
        rd_en = 1'b1; addr_odd = odd;
        #1;
        d = rdata; ack = poll_ack;
        @(negedge clk);
        rd_en = 1'b0; addr_odd = 1'b0;
        #1;
    endtask

    task automatic full_init(input logic [7:0] b2, input logic [7:0] b3, input logic [7:0] b4);
        wr(1'b0, 8'h19);
        wr(1'b1, b2);
        wr(1'b1, b3);
        wr(1'b1, b4);
    endtask

    task automatic t_reset;
        logic [7:0] d;
        check("R1 init_done", init_done, 0);
        check("R1 mask", mask_vec, 0);
        check("R1 cascade", cascade_id, 7);
        check("R1 base", vec_base, 0);
        check("R1 strobes", {cmd_valid, prio_restore, poll_ack, special_mask, nested_special}, 0);
        check("R1 rdata idle", rdata, 0);
        d = 0;
    endtask

    task automatic t_pre_init;
        logic [7:0] d; logic a;
        wr(1'b1, 8'hA5);
        check("R4 mask before setup", mask_vec, 0);
        wr(1'b0, 8'h20);
        check("R10 no cmd before setup", cmd_valid, 0);
        wr(1'b0, 8'h6C);
        check("R10 no smm before setup", special_mask, 0);
        rd(1'b0, d, a);
        check("R10 no poll before setup", a, 0);
    endtask

    task automatic t_init;
        wr(1'b0, 8'h19);
        check("R2 prio_restore pulse", prio_restore, 1);
        check("R2 init_done low", init_done, 0);
        @(negedge clk); #1;
        check("R2 prio_restore one cycle", prio_restore, 0);
        wr(1'b1, 8'h70);
        check("R4 mask in setup", mask_vec, 0);
        check("R3 base", vec_base, 5'h0E);
        // restart mid-sequence: next odd byte is base again
        wr(1'b0, 8'h19);
        wr(1'b1, 8'h48);
        check("R3 base after restart", vec_base, 5'h09);
        check("R3 cascade untouched", cascade_id, 7);
        wr(1'b1, 8'h04);
        check("R3 cascade", cascade_id, 8'h04);
        check("R4 mask in setup 2", mask_vec, 0);
        check("R3 not done yet", init_done, 0);
        wr(1'b1, 8'h11);
        check("R3 sfnm", nested_special, 1);
        check("R3 done", init_done, 1);
        check("R4 mask after setup", mask_vec, 0);
    endtask

    task automatic t_mask;
        logic [7:0] d; logic a;
        wr(1'b1, 8'h5A);
        check("R5 mask load", mask_vec, 8'h5A);
        rd(1'b1, d, a);
        check("R5 mask read", d, 8'h5A);
        wr(1'b1, 8'hFF);
        rd(1'b1, d, a);
        check("R5 mask read all", d, 8'hFF);
    endtask

    task automatic t_cmd;
        wr(1'b0, 8'h20);
        check("R6 nonspecific", {cmd_valid, cmd_code, cmd_level}, {1'b1, 3'b001, 3'd0});
        @(negedge clk); #1;
        check("R6 one cycle", cmd_valid, 0);
        wr(1'b0, 8'h63);
        check("R6 specific", {cmd_valid, cmd_code, cmd_level}, {1'b1, 3'b011, 3'd3});
        wr(1'b0, 8'hC5);
        check("R6 set prio", {cmd_valid, cmd_code, cmd_level}, {1'b1, 3'b110, 3'd5});
        wr(1'b0, 8'h42);
        check("R6 no-op code", cmd_valid, 0);
        wr(1'b0, 8'h81);
        check("R6 reserved code", cmd_valid, 0);
    endtask

    task automatic t_smm;
        wr(1'b0, 8'h68);
        check("R7 special on", special_mask, 1);
        wr(1'b0, 8'h28);
        check("R7 01 no action", special_mask, 1);
        wr(1'b0, 8'h08);
        check("R7 00 no action", special_mask, 1);
        wr(1'b0, 8'h48);
        check("R7 normal", special_mask, 0);
    endtask

    task automatic t_sel;
        logic [7:0] d; logic a;
        req_vec = 8'h3C; isr_vec = 8'h81;
        rd(1'b0, d, a);
        check("R8 default request", d, 8'h3C);
        wr(1'b0, 8'h0B);
        rd(1'b0, d, a);
        check("R8 in-service", d, 8'h81);
        rd(1'b0, d, a);
        check("R8 sticky", d, 8'h81);
        wr(1'b0, 8'h09);
        rd(1'b0, d, a);
        check("R8 01 no action", d, 8'h81);
        wr(1'b0, 8'h0A);
        rd(1'b0, d, a);
        check("R8 back to request", d, 8'h3C);
    endtask

    task automatic t_poll;
        logic [7:0] d; logic a;
        pend_valid = 1'b1; pend_level = 3'd5;
        wr(1'b0, 8'h0C);
        rd(1'b0, d, a);
        check("R9 status", d, 8'h85);
        check("R9 ack", a, 1);
        rd(1'b0, d, a);
        check("R9 consumed", {a, d}, {1'b0, 8'h3C});
        pend_valid = 1'b0; pend_level = 3'd6;
        wr(1'b0, 8'h0C);
        rd(1'b1, d, a);
        check("R9 none pending", {a, d}, {1'b1, 8'h00});
        rd(1'b1, d, a);
        check("R9 odd read after poll", {a, d}, {1'b0, 8'hFF});
    endtask

    task automatic t_reinit;
        logic [7:0] d; logic a;
        wr(1'b0, 8'h68);
        wr(1'b0, 8'h0B);
        wr(1'b0, 8'h19);
        check("R2 mask cleared", mask_vec, 0);
        check("R2 smm cleared", special_mask, 0);
        check("R2 cascade 7", cascade_id, 7);
        check("R2 sfnm cleared", nested_special, 0);
        wr(1'b1, 8'hF8);
        wr(1'b1, 8'h02);
        wr(1'b1, 8'h01);
        check("R3 second setup", {vec_base, cascade_id, nested_special, init_done},
              {5'h1F, 8'h02, 1'b0, 1'b1});
        rd(1'b0, d, a);
        check("R2 select request", d, 8'h3C);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        t_reset();
        t_pre_init();
        t_init();
        t_mask();
        t_cmd();
        t_smm();
        t_sel();
        t_poll();
        t_reinit();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule